// File: doc/BRIEF.md
# Quarter-Wave Table Numerically Controlled Oscillator

This block is a phase-accumulator oscillator that emits one signed 8-bit cosine sample per clock. Each enabled clock the 16-bit phase register advances by a fixed centre step of one sixteenth of a turn plus a signed correction taken from an 8-bit tuning word. In a tracking loop that word comes from the loop filter. With the tuning word at zero the output repeats every 16 enabled clocks, so a 16 MHz sample rate gives a 1 MHz centre tone.

The upper ten phase bits address one full cosine cycle of 1024 points. Only the first quarter is held, as 257 magnitudes from 0 to π/2 inclusive, and these are computed at elaboration. The other three quarters are formed by mirroring the address and flipping the sign. The sample is registered, and the raw phase is also brought out.

Top module: `qlut_nco`

## Requirements
- R1: While `rst` is high at a rising edge, `phase_out` becomes 0 and `cos_out` becomes +127 on that edge.
- R2: With `tune_word` = 0, each enabled clock adds 0x1000 to `phase_out`, so 16 enabled clocks return the phase to its starting value.
- R3: The per-step increment is 0x1000 + 4 × (signed `tune_word`), which spans 0x0E00 (tune −128) to 0x11FC (tune +127). Positive tuning speeds the phase and negative tuning slows it.
- R4: With `step_en` low, `phase_out` keeps its value and `cos_out` stays at the sample of that phase.
- R5: The table address is `phase_out[15:6]`, and the quadrant is `phase_out[15:14]`.
- R6: In quadrants 0 and 2 the quarter index is the low 8 address bits. In quadrants 1 and 3 it is 256 minus those bits, so index 256 is used at addresses 256 and 768.
- R7: Samples are negative or zero in quadrants 1 and 2, and non-negative in quadrants 0 and 3. Address 512 gives −127.
- R8: Sample magnitude is round(127·|cos(2π·addr/1024)|) in 8-bit two's complement, and −128 never appears.
- R9: After each rising edge outside reset, `cos_out` holds the sample of the phase that `phase_out` showed just before that edge.
- R10: The phase wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Sample strobe; the phase advances only when high |
| tune_word | input | 8 | Signed frequency correction |
| cos_out | output | 8 | Signed cosine sample, registered |
| phase_out | output | 16 | Phase accumulator value |

## Verification
A zero tuning word puts the phase on multiples of 0x1000. That lands on the four quadrant boundaries and both mirrored index-256 points, so it separates mirror and sign faults from table-content faults. Full-scale positive and negative words separate faults in sign extension and scaling, and gated strobes catch a phase that moves without the strobe. Long random runs of tuning words and strobes sweep most table addresses and many wraps, and they check the one-cycle sample latency against the phase seen on the port.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Cosine magnitude for quarter-table entry k of qlast (qlast = 90 degrees),
  // scaled to amp and rounded; Taylor series so it folds at elaboration.
  function automatic int quarter_amp(input int k, input int qlast, input int amp);
    real x;
    real term;
    real sum;
    x    = 1.5707963267948966 * real'(k) / real'(qlast);
    term = 1.0;
    sum  = 1.0;
    for (int n = 1; n <= 14; n++) begin
      term = -term * x * x / real'((2 * n - 1) * (2 * n));
      sum  = sum + term;
    end
    return $rtoi(real'(amp) * sum + 0.5);
  endfunction

  // Quadrants 1 and 2 carry a negative sample.
  function automatic logic quad_negate(input logic [1:0] q);
    return q[1] ^ q[0];
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W      = 16,
  parameter int TUNE_W     = 8,
  parameter int TUNE_SHIFT = 2,
  parameter logic [ACC_W-1:0] CENTER_INC = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [TUNE_W-1:0] tune_word,
  output logic [ACC_W-1:0]  step_inc,
  output logic [ACC_W-1:0]  phase
);
  localparam int EXT_W = ACC_W - TUNE_W;

  logic [ACC_W-1:0] tune_ext;

  assign tune_ext = {{EXT_W{tune_word[TUNE_W-1]}}, tune_word} << TUNE_SHIFT;
  assign step_inc = CENTER_INC + tune_ext;

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (step_en) phase <= phase + step_inc;
  end
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int QTR_W = 8,
  parameter int AMP_W = 8
) (
  input  logic [QTR_W:0]   idx,
  output logic [AMP_W-1:0] mag
);
  import nco_pkg::*;
  localparam int QPTS = (1 << QTR_W) + 1;
  localparam int AMAX = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-1:0] rom [QPTS];

  for (genvar g = 0; g < QPTS; g++) begin : g_ent
    assign rom[g] = AMP_W'(quarter_amp(g, QPTS - 1, AMAX));
  end

  assign mag = (int'(idx) < QPTS) ? rom[idx] : '0;
endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [AMP_W-1:0]  mag,
  output logic [1:0]        quad,
  output logic [ADDR_W-2:0] q_idx,
  output logic [AMP_W-1:0]  sample
);
  import nco_pkg::*;
  localparam int QTR_W = ADDR_W - 2;

  logic [QTR_W-1:0] low;

  assign quad   = addr[ADDR_W-1 -: 2];
  assign low    = addr[QTR_W-1:0];
  assign q_idx  = quad[0] ? ((QTR_W+1)'(1 << QTR_W) - {1'b0, low}) : {1'b0, low};
  assign sample = quad_negate(quad) ? (AMP_W'(0) - mag) : mag;
endmodule

// File: rtl/qlut_nco.sv
module qlut_nco #(
  parameter int ACC_W      = 16,
  parameter int ADDR_W     = 10,
  parameter int AMP_W      = 8,
  parameter int TUNE_W     = 8,
  parameter int TUNE_SHIFT = 2,
  parameter logic [ACC_W-1:0] CENTER_INC = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [TUNE_W-1:0] tune_word,
  output logic [AMP_W-1:0]  cos_out,
  output logic [ACC_W-1:0]  phase_out
);
  localparam int QTR_W = ADDR_W - 2;
  localparam logic [AMP_W-1:0] AMP_PEAK = AMP_W'((1 << (AMP_W - 1)) - 1);

  logic [ACC_W-1:0]  step_inc;
  logic [ACC_W-1:0]  phase;
  logic [ADDR_W-1:0] tbl_addr;
  logic [1:0]        cur_quad;
  logic [QTR_W:0]    q_idx;
  logic [AMP_W-1:0]  q_mag;
  logic [AMP_W-1:0]  next_sample;

  nco_phase_acc #(
    .ACC_W(ACC_W), .TUNE_W(TUNE_W), .TUNE_SHIFT(TUNE_SHIFT), .CENTER_INC(CENTER_INC)
  ) u_acc (
    .clk(clk), .rst(rst), .step_en(step_en), .tune_word(tune_word),
    .step_inc(step_inc), .phase(phase)
  );

  assign tbl_addr = phase[ACC_W-1 -: ADDR_W];

  nco_fold #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_fold (
    .addr(tbl_addr), .mag(q_mag), .quad(cur_quad), .q_idx(q_idx), .sample(next_sample)
  );

  nco_quarter_rom #(.QTR_W(QTR_W), .AMP_W(AMP_W)) u_rom (
    .idx(q_idx), .mag(q_mag)
  );

  always_ff @(posedge clk) begin
    if (rst) cos_out <= AMP_PEAK;
    else     cos_out <= next_sample;
  end

  assign phase_out = phase;
endmodule

// File: rtl/nco_chk.sv
module nco_chk #(
  parameter int ACC_W  = 16,
  parameter int AMP_W  = 8,
  parameter int TUNE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic [TUNE_W-1:0] tune_word,
  input logic [AMP_W-1:0]  cos_out,
  input logic [ACC_W-1:0]  phase_out,
  input logic [1:0]        cur_quad
);
  localparam logic signed [AMP_W-1:0] PEAK = AMP_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [AMP_W-1:0] MOST_NEG = AMP_W'(1 << (AMP_W - 1));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && $signed(cos_out) == PEAK));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> phase_out == ACC_W'($past(phase_out) + 16'h1000
                                     + ACC_W'($signed($past(tune_word)) * 4)));

  // R4
  hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(phase_out));

  // R7
  neg_half_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_quad == 2'd1 || cur_quad == 2'd2) |=> $signed(cos_out) <= 0);

  // R7
  pos_half_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_quad == 2'd0 || cur_quad == 2'd3) |=> $signed(cos_out) >= 0);

  // R9
  peak_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_out[ACC_W-1:ACC_W-10] == 10'd0) |=> $signed(cos_out) == PEAK);

  // R9
  trough_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_out[ACC_W-1:ACC_W-10] == 10'd512) |=> $signed(cos_out) == -PEAK);

  // R6
  mirror_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_out[ACC_W-1:ACC_W-10] == 10'd256 || phase_out[ACC_W-1:ACC_W-10] == 10'd768)
    |=> cos_out == '0);

  // R8
  no_most_neg_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |-> $signed(cos_out) != MOST_NEG);
endmodule

bind qlut_nco nco_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W), .TUNE_W(TUNE_W)) u_nco_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .tune_word(tune_word),
  .cos_out(cos_out), .phase_out(phase_out), .cur_quad(cur_quad)
);

// File: tb/test_qlut_nco.sv
module test_qlut_nco;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [7:0]  tune_word = 8'd0;
  logic [7:0]  cos_out;
  logic [15:0] phase_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [15:0] m_phase;
  int          m_cos;

  qlut_nco i_qlut_nco (
    .clk(clk), .rst(rst), .step_en(step_en), .tune_word(tune_word),
    .cos_out(cos_out), .phase_out(phase_out)
  );

  always #10 clk = ~clk;

  // Expected sample from the full-cycle angle, rounded by magnitude.
  function automatic int ref_cos(input logic [15:0] ph);
    real c;
    c = 127.0 * $cos(2.0 * 3.141592653589793 * real'(int'(ph >> 6)) / 1024.0);
    if (c >= 0.0) return $rtoi(c + 0.5);
    return -$rtoi(-c + 0.5);
  endfunction

  function automatic logic [15:0] ref_inc(input logic [7:0] t);
    int s;
    s = int'($signed(t));
    return 16'(4096 + 4 * s);
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic check_both(input string req);
    check({req, " phase"}, int'(phase_out), int'(m_phase));
    check({req, " sample"}, int'($signed(cos_out)), m_cos);
  endtask

  // Drive one clock; inputs change at negedge, the model follows the edge.
  task automatic step(input logic en, input logic [7:0] t);
    step_en   = en;
    tune_word = t;
    @(posedge clk);
    m_cos = ref_cos(m_phase);
    if (en) m_phase = m_phase + ref_inc(t);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] start_ph;
    process::self().srandom(32'd20240611);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_phase = 16'd0;
    m_cos   = 127;
    // R1: reset state
    check_both("R1");
    rst = 1'b0;

    // R2, R5, R6, R7: zero tune visits every 64th address incl. 256/512/768
    start_ph = m_phase;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 8'd0);
      check_both("R2");
    end
    check("R2 full cycle", int'(phase_out), int'(start_ph));
    step(1'b1, 8'd0);
    check_both("R9");

    // R3: full-scale positive, then full-scale negative tuning
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 8'h7F);
      check_both("R3 pos");
    end
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 8'h80);
      check_both("R3 neg");
    end

    // R4: strobe low with a nonzero tune leaves phase and sample unchanged
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 8'h55);
      check_both("R4");
    end

    // R1 again mid-run
    rst = 1'b1;
    step(1'b1, 8'h33);
    m_phase = 16'd0;
    m_cos   = 127;
    check_both("R1 mid");
    rst = 1'b0;

    // R8, R9, R10: random tuning and strobes across many wraps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 8'($urandom));
      check_both("R8/R9/R10");
    end

    finish_run();
  end
endmodule